// File: doc/BRIEF.md
# One-Way Counter Bank

This block keeps a small bank of counters for a contactless tag. Each counter can only climb. The command decoder reaches the bank with one of two operations: a read that returns the selected counter, or an increment that adds a supplied amount to it. Each command is a single-cycle strobe carrying an operation bit, a counter index and an increment amount. One cycle later the bank answers with an acknowledge or negative-acknowledge flag and a 24-bit data word.

An increment is applied whole or not at all. If the sum would not fit in the counter width, the command is refused and the stored value stays exactly as it was. No command can wrap a counter or lower it. The registers here stand in for non-volatile cells, and only a dedicated initialization input returns them to zero. The ordinary logic reset clears the response path only and leaves the counts alone.

Top module: `mono_ctr_bank`

## Requirements
- R1: The bank holds three independent 24-bit counters at indices 0, 1 and 2. A command on one index never changes the other two.
- R2: An increment (cmd_op = 1) on a valid index whose sum fits in 24 bits adds cmd_inc to the counter and answers with rsp_ack = 1. Its rsp_data is the new value.
- R3: An increment whose sum exceeds 0xFFFFFF answers with rsp_ack = 0 and leaves the counter unchanged. Its rsp_data is the unchanged value. A sum of exactly 0xFFFFFF is accepted.
- R4: An increment of zero is accepted with rsp_ack = 1 and leaves the value unchanged.
- R5: A command whose index is 3 answers with rsp_ack = 0 and rsp_data = 0, whatever the operation, and changes no counter.
- R6: A read (cmd_op = 0) on a valid index answers with rsp_ack = 1 and the stored value, and changes no counter. The value is sent least significant byte first: rsp_data[7:0] is byte 0, [15:8] is byte 1 and [23:16] is byte 2.
- R7: A cycle with init = 1 clears every counter to zero. The reset rst_n leaves the counters untouched.
- R8: rsp_valid is 1 in exactly the cycle after each cycle with cmd_valid = 1, and 0 otherwise, including during reset.
- R9: No counter value ever decreases except through init.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the response path |
| init | input | 1 | Synchronous clear of all counters |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 1 | 0 = read, 1 = increment |
| cmd_idx | input | 2 | Counter index |
| cmd_inc | input | 24 | Increment amount |
| rsp_valid | output | 1 | Response present |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = negative acknowledge |
| rsp_data | output | 24 | Counter value, byte 0 in the low bits |

## Verification
The hardest case to reach from the ports is the overflow boundary. The stimulus must first pump a counter close to 0xFFFFFF through accepted increments. It then probes sums one below, exactly at and one above the limit, both by single steps and by larger amounts. A long pseudo-random sweep then drives all three counters, and the invalid index, into saturation. Throughout the sweep, an arithmetic model in the bench predicts every acknowledge and value, including the refusals.

// File: rtl/mctr_pkg.sv
package mctr_pkg;
   typedef enum logic {
      OP_READ = 1'b0,
      OP_INCR = 1'b1
   } mctr_op_e;
endpackage

// File: rtl/mctr_cell.sv
module mctr_cell #(
   parameter int unsigned CTR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             inc_en,
   input  logic [CTR_W-1:0] inc_val,
   output logic [CTR_W-1:0] value,
   output logic [CTR_W-1:0] next_val,
   output logic             fits
);
   logic [CTR_W:0] sum;

   assign sum      = {1'b0, value} + {1'b0, inc_val};
   assign fits     = ~sum[CTR_W];
   assign next_val = fits ? sum[CTR_W-1:0] : value;

   always_ff @(posedge clk) begin
      if (init)
         value <= '0;
      else if (inc_en && fits)
         value <= sum[CTR_W-1:0];
   end

   // R9
   mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(init) |-> value >= $past(value));
   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !init && (({1'b0, value} + {1'b0, inc_val}) > {1'b0, {CTR_W{1'b1}}})) |=> $stable(value));
   // R7
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> value == '0);
endmodule

// File: rtl/mctr_rsp.sv
module mctr_rsp #(
   parameter int unsigned CTR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  logic             d_ack,
   input  logic [CTR_W-1:0] d_data,
   output logic             rsp_valid,
   output logic             rsp_ack,
   output logic [CTR_W-1:0] rsp_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= d_valid;
         rsp_ack   <= d_valid & d_ack;
         if (d_valid)
            rsp_data <= d_data;
      end
   end

   // R8
   ack_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> rsp_valid);
endmodule

// File: rtl/mono_ctr_bank.sv
module mono_ctr_bank #(
   parameter int unsigned NUM_CTR = 3,
   parameter int unsigned CTR_W   = 24,
   parameter int unsigned IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             cmd_valid,
   input  logic             cmd_op,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [CTR_W-1:0] cmd_inc,
   output logic             rsp_valid,
   output logic             rsp_ack,
   output logic [CTR_W-1:0] rsp_data
);
   import mctr_pkg::*;

   localparam int unsigned   RD_BYTES  = CTR_W / 8;
   localparam logic [IDX_W:0] NUM_CTR_L = (IDX_W + 1)'(NUM_CTR);

   if (CTR_W % 8 != 0 || RD_BYTES == 0) begin : g_bad_width
      $error("CTR_W must be a nonzero multiple of 8");
   end
   if (NUM_CTR == 0 || NUM_CTR > (1 << IDX_W)) begin : g_bad_count
      $error("NUM_CTR must be 1 .. 2**IDX_W");
   end

   mctr_op_e         op;
   logic             sel_ok;
   logic             is_incr;
   logic [CTR_W-1:0] val_a  [NUM_CTR];
   logic [CTR_W-1:0] nxt_a  [NUM_CTR];
   logic             fit_a  [NUM_CTR];
   logic             d_ack;
   logic [CTR_W-1:0] d_data;

   assign op      = mctr_op_e'(cmd_op);
   assign sel_ok  = {1'b0, cmd_idx} < NUM_CTR_L;
   assign is_incr = (op == OP_INCR);

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      logic hit;
      assign hit = cmd_valid && sel_ok && (cmd_idx == IDX_W'(g));

      mctr_cell #(.CTR_W(CTR_W)) i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .init     (init),
         .inc_en   (hit && is_incr),
         .inc_val  (cmd_inc),
         .value    (val_a[g]),
         .next_val (nxt_a[g]),
         .fits     (fit_a[g])
      );

      // R6
      read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && !cmd_op && !init) |=> $stable(val_a[g]));
      // R1
      other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && (cmd_idx != IDX_W'(g)) && !init) |=> $stable(val_a[g]));
   end

   always_comb begin
      d_ack  = 1'b0;
      d_data = '0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (sel_ok && cmd_idx == IDX_W'(k)) begin
            d_ack  = is_incr ? fit_a[k] : 1'b1;
            d_data = is_incr ? nxt_a[k] : val_a[k];
         end
      end
   end

   mctr_rsp #(.CTR_W(CTR_W)) i_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_valid   (cmd_valid),
      .d_ack     (d_ack),
      .d_data    (d_data),
      .rsp_valid (rsp_valid),
      .rsp_ack   (rsp_ack),
      .rsp_data  (rsp_data)
   );

   // R5
   bad_idx_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ({1'b0, cmd_idx} >= NUM_CTR_L)) |=> (rsp_valid && !rsp_ack));
   // R8
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);
   // R8
   no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);
endmodule

// File: tb/test_mono_ctr_bank.sv
module test_mono_ctr_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_op = 1'b0;
   logic [1:0]  cmd_idx = '0;
   logic [23:0] cmd_inc = '0;
   logic        rsp_valid;
   logic        rsp_ack;
   logic [23:0] rsp_data;

   int checks = 0;
   int failures = 0;
   logic [23:0] model [3];
   logic [31:0] lcg = 32'h1234_5678;

   always #2.5 clk = ~clk;

   mono_ctr_bank i_mono_ctr_bank (
      .clk(clk), .rst_n(rst_n), .init(init), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_inc(cmd_inc),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic op, input logic [1:0] idx, input logic [23:0] inc,
                          input string req);
      logic        e_ack;
      logic [23:0] e_data;
      logic [24:0] s;
      if (idx > 2'd2) begin
         e_ack = 1'b0; e_data = '0;
      end else if (!op) begin
         e_ack = 1'b1; e_data = model[idx];
      end else begin
         s = {1'b0, model[idx]} + {1'b0, inc};
         if (s > 25'h0FF_FFFF) begin
            e_ack = 1'b0; e_data = model[idx];
         end else begin
            model[idx] = s[23:0];
            e_ack = 1'b1; e_data = s[23:0];
         end
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_inc = inc;
      @(posedge clk); #1;
      chk({req, " R8 valid"}, {31'd0, rsp_valid}, 32'd1);
      chk({req, " ack"}, {31'd0, rsp_ack}, {31'd0, e_ack});
      chk({req, " data"}, {8'd0, rsp_data}, {8'd0, e_data});
      @(negedge clk);
      cmd_valid = 1'b0;
      @(posedge clk); #1;
      chk("R8 idle", {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic read_all(input string req);
      for (int i = 0; i < 3; i++) run_cmd(1'b0, 2'(i), 24'd0, req);
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) model[i] = '0;
      repeat (4) @(posedge clk);
      #1;
      chk("R8 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
      init = 1'b0; rst_n = 1'b1;
      read_all("R7 after init");

      // R2 / R1: distinct patterns per counter
      run_cmd(1'b1, 2'd0, 24'd5, "R2 inc c0");
      run_cmd(1'b1, 2'd1, 24'h000100, "R2 inc c1");
      run_cmd(1'b1, 2'd2, 24'h123456, "R2 inc c2");
      run_cmd(1'b1, 2'd0, 24'h00FF00, "R2 inc c0 again");
      read_all("R1 independence");

      // R4 zero increment
      run_cmd(1'b1, 2'd2, 24'd0, "R4 zero inc");
      run_cmd(1'b0, 2'd2, 24'd0, "R4 read back");

      // R6 byte order: c2 holds 0x123456
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 1'b0; cmd_idx = 2'd2;
      @(posedge clk); #1;
      chk("R6 byte0", {24'd0, rsp_data[7:0]}, 32'h56);
      chk("R6 byte1", {24'd0, rsp_data[15:8]}, 32'h34);
      chk("R6 byte2", {24'd0, rsp_data[23:16]}, 32'h12);
      @(negedge clk); cmd_valid = 1'b0;

      // R3 boundary on c1
      run_cmd(1'b1, 2'd1, 24'hFFFFFF - model[1] - 24'd1, "R3 fill to FFFFFE");
      run_cmd(1'b1, 2'd1, 24'd2, "R3 over by one");
      run_cmd(1'b1, 2'd1, 24'd1, "R3 exactly max");
      run_cmd(1'b1, 2'd1, 24'd1, "R3 over at max");
      run_cmd(1'b1, 2'd1, 24'hFFFFFF, "R3 large over");
      run_cmd(1'b1, 2'd1, 24'd0, "R4 zero at max");
      read_all("R3 R1 after overflow");

      // R5 invalid index
      run_cmd(1'b0, 2'd3, 24'd0, "R5 read idx3");
      run_cmd(1'b1, 2'd3, 24'd7, "R5 inc idx3");
      read_all("R5 no change");

      // R7 reset does not clear, init does
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      read_all("R7 rst_n keeps counts");
      @(negedge clk); init = 1'b1;
      @(negedge clk); init = 1'b0;
      for (int i = 0; i < 3; i++) model[i] = '0;
      read_all("R7 init clears");

      // R9 sweep: pseudo-random ops until saturation, model predicts everything
      for (int n = 0; n < 3000; n++) begin
         logic [23:0] v;
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         case (lcg[31:30])
            2'd0: v = {16'd0, lcg[7:0]};
            2'd1: v = {4'd0, lcg[19:0]};
            2'd2: v = 24'hFFFFFF - model[lcg[28] ? 1 : 0] + 24'(lcg[1:0]) - 24'd1;
            default: v = lcg[23:0];
         endcase
         run_cmd(lcg[27], lcg[26:25], v, "R9 sweep");
      end
      read_all("R9 final");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule